// File: doc/BRIEF.md
# Section DCC Byte Insertion Sequencer

The sequencer stores a multiframe of section data-communication bytes and delivers the three bytes that belong to each frame to the transmit overhead inserter. There are 24 frames per multiframe and three bytes per frame, called D1, D2 and D3. That makes 72 bytes in total. A host loads them through a plain write port into 36 sixteen-bit registers, two bytes per register. Because three is odd, register boundaries do not line up with frame boundaries.

A frame counter advances on every frame-start pulse. A multiframe-sync pulse pulls the counter back to the first frame of the cycle. The inserter raises one slot-request line per byte position. One clock later the block drives that byte and a matching valid strobe. The requested byte is taken from storage in the same clock as the request. If a host write to that register lands in the same clock, the old contents are still delivered, and the new contents appear on the next read.

Top module: `sdcc_seq`

## Requirements
- R1: After reset, `dcc_byte_o` and `dcc_valid_o` are all zero, the frame counter is at frame 1 (index 0), and every storage register reads zero.
- R2: Byte k (0=D1, 1=D2, 2=D3) of frame n (index 0..23) has flat index i = 3n+k. It is stored in register i/2. Even i uses bits [15:8] and odd i uses bits [7:0].
- R3: Each `frame_start_i` pulse advances the frame index by one. From index 23 it wraps to index 0.
- R4: `mf_sync_i` sets the frame index to 0 on the next clock. It takes priority over a simultaneous `frame_start_i`.
- R5: When `slot_i[k]` is high in a clock, on the next clock `dcc_valid_o[k]` is high and lane k of `dcc_byte_o` (bits [8k+7:8k]) holds byte k of the current frame.
- R6: When `slot_i[k]` is low, `dcc_valid_o[k]` is low on the next clock and lane k of `dcc_byte_o` keeps its value, even if the host writes storage.
- R7: A write to the register being read in the same clock does not alter the byte output in that read. The next read of that byte returns the new value.
- R8: Writes with `wr_addr_i` of 36 or more have no effect on any stored byte.
- R9: Several slot lines may be high in one clock. Each requested lane is then delivered in the same following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 6 | Host register index (0..35 valid) |
| wr_data_i | input | 16 | Host write data, first byte in [15:8] |
| frame_start_i | input | 1 | One-clock pulse at each frame start |
| mf_sync_i | input | 1 | Multiframe sync: return to frame 1 |
| slot_i | input | 3 | Per-byte slot request, bit k for Dk+1 |
| dcc_byte_o | output | 24 | Output bytes, lane k in [8k+7:8k] |
| dcc_valid_o | output | 3 | Per-lane valid strobe, one clock after request |

## Verification
The bench builds the block with its default values: 24 frames, three bytes per frame and 16-bit registers. This configuration is small enough for exhaustive sweeps. Every byte of every frame is read over two full multiframes, so each packing position and both counter wraps are covered. Every unused address from 36 to 63 is written, and every stored byte is then checked again. Directed cases cover sync priority, a write and a read of the same register in the same clock, held lanes, and all three lanes requested at once.

// File: rtl/sdcc_pkg.sv
package sdcc_pkg;
  localparam int unsigned DCC_FRAMES   = 24;
  localparam int unsigned DCC_PER_FRM  = 3;
  localparam int unsigned DCC_BYTE_W   = 8;
  localparam int unsigned DCC_REG_W    = 16;
endpackage

// File: rtl/sdcc_frame_ctr.sv
module sdcc_frame_ctr #(
  parameter int unsigned NUM_FRAMES = 24,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               mf_sync_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [FRAME_W-1:0] LAST = FRAME_W'(NUM_FRAMES - 1);

  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            frame_q <= '0;
    else if (mf_sync_i)     frame_q <= '0;
    else if (frame_start_i) frame_q <= (frame_q == LAST) ? '0 : frame_q + 1'b1;
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/sdcc_slot_map.sv
module sdcc_slot_map #(
  parameter int unsigned NUM_FRAMES  = 24,
  parameter int unsigned PER_FRAME   = 3,
  parameter int unsigned LANES       = 2,
  parameter int unsigned SLOT        = 0,
  localparam int unsigned FRAME_W    = $clog2(NUM_FRAMES),
  localparam int unsigned NUM_BYTES  = NUM_FRAMES * PER_FRAME,
  localparam int unsigned IDX_W      = $clog2(NUM_BYTES),
  localparam int unsigned NUM_REGS   = (NUM_BYTES + LANES - 1) / LANES,
  localparam int unsigned ADDR_W     = $clog2(NUM_REGS),
  localparam int unsigned LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [FRAME_W-1:0] frame_i,
  output logic [ADDR_W-1:0]  reg_idx_o,
  output logic [LANE_W-1:0]  lane_o
);
  logic [IDX_W-1:0] flat;

  always_comb begin
    flat      = IDX_W'(frame_i) * IDX_W'(PER_FRAME) + IDX_W'(SLOT);
    reg_idx_o = ADDR_W'(flat / IDX_W'(LANES));
    lane_o    = LANE_W'(flat % IDX_W'(LANES));
  end
endmodule

// File: rtl/sdcc_regbank.sv
module sdcc_regbank #(
  parameter int unsigned NUM_REGS = 36,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned PORTS    = 3,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [REG_W-1:0]             wr_data_i,
  input  logic [PORTS-1:0][ADDR_W-1:0] rd_addr_i,
  output logic [PORTS-1:0][REG_W-1:0]  rd_data_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] mem_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[r] <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(r))) mem_q[r] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_addr_i[p]];
  end
endmodule

// File: rtl/sdcc_seq.sv
module sdcc_seq
  import sdcc_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = DCC_FRAMES,
  parameter int unsigned PER_FRAME  = DCC_PER_FRM,
  parameter int unsigned BYTE_W     = DCC_BYTE_W,
  parameter int unsigned REG_W      = DCC_REG_W,
  localparam int unsigned LANES     = REG_W / BYTE_W,
  localparam int unsigned NUM_BYTES = NUM_FRAMES * PER_FRAME,
  localparam int unsigned NUM_REGS  = (NUM_BYTES + LANES - 1) / LANES,
  localparam int unsigned ADDR_W    = $clog2(NUM_REGS),
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES),
  localparam int unsigned LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [REG_W-1:0]            wr_data_i,
  input  logic                        frame_start_i,
  input  logic                        mf_sync_i,
  input  logic [PER_FRAME-1:0]        slot_i,
  output logic [PER_FRAME*BYTE_W-1:0] dcc_byte_o,
  output logic [PER_FRAME-1:0]        dcc_valid_o
);
  logic [FRAME_W-1:0]                   frame_q;
  logic [PER_FRAME-1:0][ADDR_W-1:0]     rd_addr;
  logic [PER_FRAME-1:0][LANE_W-1:0]     rd_lane;
  logic [PER_FRAME-1:0][REG_W-1:0]      rd_data;
  logic [PER_FRAME-1:0][BYTE_W-1:0]     byte_q;
  logic [PER_FRAME-1:0]                 valid_q;
  logic                                 wr_ok;

  // out-of-range addresses dropped
  assign wr_ok = wr_en_i && (wr_addr_i < ADDR_W'(NUM_REGS));

  sdcc_frame_ctr #(.NUM_FRAMES(NUM_FRAMES)) u_ctr (
    .clk_i, .rst_ni, .frame_start_i, .mf_sync_i, .frame_o(frame_q)
  );

  sdcc_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .PORTS(PER_FRAME)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_ok), .wr_addr_i, .wr_data_i,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  for (genvar k = 0; k < PER_FRAME; k++) begin : g_slot
    logic [BYTE_W-1:0] sel;

    sdcc_slot_map #(
      .NUM_FRAMES(NUM_FRAMES), .PER_FRAME(PER_FRAME), .LANES(LANES), .SLOT(k)
    ) u_map (
      .frame_i(frame_q), .reg_idx_o(rd_addr[k]), .lane_o(rd_lane[k])
    );

    // lane 0 is the most significant byte
    assign sel = BYTE_W'(rd_data[k] >> ((LANES - 1 - rd_lane[k]) * BYTE_W));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[k]  <= '0;
        valid_q[k] <= 1'b0;
      end else begin
        valid_q[k] <= slot_i[k];
        if (slot_i[k]) byte_q[k] <= sel;
      end
    end

    assign dcc_byte_o[k*BYTE_W +: BYTE_W] = byte_q[k];
  end

  assign dcc_valid_o = valid_q;
endmodule

// File: rtl/sdcc_seq_chk.sv
module sdcc_seq_chk #(
  parameter int unsigned NUM_FRAMES = 24,
  parameter int unsigned PER_FRAME  = 3,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        frame_start_i,
  input logic                        mf_sync_i,
  input logic [PER_FRAME-1:0]        slot_i,
  input logic [PER_FRAME*BYTE_W-1:0] dcc_byte_o,
  input logic [PER_FRAME-1:0]        dcc_valid_o,
  input logic [FRAME_W-1:0]          frame_q
);
  assert_frame_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !mf_sync_i && frame_q == FRAME_W'(NUM_FRAMES - 1)) |=> frame_q == '0);

  assert_frame_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !mf_sync_i && frame_q < FRAME_W'(NUM_FRAMES - 1))
      |=> frame_q == $past(frame_q) + 1'b1);

  assert_frame_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !mf_sync_i) |=> $stable(frame_q));

  assert_sync_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_sync_i |=> frame_q == '0);

  assert_valid_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dcc_valid_o == $past(slot_i));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == '0) |=> $stable(dcc_byte_o));

  always_comb begin
    if (rst_ni) assert_frame_range_R3: assert (frame_q < FRAME_W'(NUM_FRAMES));
  end
endmodule

bind sdcc_seq sdcc_seq_chk #(
  .NUM_FRAMES(NUM_FRAMES), .PER_FRAME(PER_FRAME), .BYTE_W(BYTE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
  .mf_sync_i(mf_sync_i), .slot_i(slot_i), .dcc_byte_o(dcc_byte_o),
  .dcc_valid_o(dcc_valid_o), .frame_q(frame_q)
);

// File: tb/sdcc_seq_bench.sv
module sdcc_seq_bench;
  localparam int NF = 24;
  localparam int PF = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        frame_start_i = 1'b0;
  logic        mf_sync_i = 1'b0;
  logic [2:0]  slot_i = '0;
  logic [23:0] dcc_byte_o;
  logic [2:0]  dcc_valid_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [NF*PF];

  always #2.5 clk_i = ~clk_i;

  sdcc_seq u_sdcc_seq (.*);

  function automatic logic [7:0] patt(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic fs();
    @(negedge clk_i); frame_start_i = 1'b1;
    @(negedge clk_i); frame_start_i = 1'b0;
  endtask

  task automatic sync();
    @(negedge clk_i); mf_sync_i = 1'b1;
    @(negedge clk_i); mf_sync_i = 1'b0;
  endtask

  // request slots s, then compare requested lanes with shadow for frame fr
  task automatic rd(logic [2:0] s, int fr, string req);
    @(negedge clk_i); slot_i = s;
    @(negedge clk_i); slot_i = '0;
    chk(req, int'(dcc_valid_o), int'(s));
    for (int k = 0; k < PF; k++)
      if (s[k]) chk(req, int'(dcc_byte_o[8*k +: 8]), int'(shadow[3*fr + k]));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 bytes", int'(dcc_byte_o), 0);
    chk("R1 valid", int'(dcc_valid_o), 0);
    for (int i = 0; i < NF*PF; i++) shadow[i] = 8'h00;
    rd(3'b111, 0, "R1 storage");

    // R2: load packing pattern
    for (int r = 0; r < NF*PF/2; r++) begin
      wr(r, {patt(2*r), patt(2*r+1)});
      shadow[2*r] = patt(2*r); shadow[2*r+1] = patt(2*r+1);
    end
    sync();

    // R2 R3 R5: two multiframes, every lane alone
    for (int f = 0; f < 2*NF; f++) begin
      for (int k = 0; k < PF; k++) rd(3'(1 << k), f % NF, "R2 R5 lane");
      if (f < NF) rd(3'b111, f % NF, "R9 all lanes");
      fs();
    end
    rd(3'b101, 0, "R3 wrap after two multiframes");

    // R4: sync mid-cycle and priority over frame_start
    for (int j = 0; j < 5; j++) fs();
    rd(3'b111, 5, "R3 step");
    @(negedge clk_i); mf_sync_i = 1'b1; frame_start_i = 1'b1;
    @(negedge clk_i); mf_sync_i = 1'b0; frame_start_i = 1'b0;
    rd(3'b111, 0, "R4 sync priority");
    fs(); fs(); sync();
    rd(3'b111, 0, "R4 sync");

    // R6: lanes hold without request, even across a write
    rd(3'b010, 0, "R6 setup");
    held = dcc_byte_o;
    wr(0, 16'h1234);
    shadow[0] = 8'h12; shadow[1] = 8'h34;
    repeat (2) @(negedge clk_i);
    chk("R6 hold", int'(dcc_byte_o), int'(held));
    chk("R6 valid low", int'(dcc_valid_o), 0);

    // R7: write and read the same register in one clock
    @(negedge clk_i);
    slot_i = 3'b001; wr_en_i = 1'b1; wr_addr_i = 6'd0; wr_data_i = 16'hA55A;
    @(negedge clk_i);
    slot_i = '0; wr_en_i = 1'b0;
    chk("R7 old byte", int'(dcc_byte_o[7:0]), 32'h12);
    shadow[0] = 8'hA5; shadow[1] = 8'h5A;
    rd(3'b001, 0, "R7 new byte");

    // R8: out-of-range writes ignored
    for (int a = NF*PF/2; a < 64; a++) wr(a, 16'hFFFF);
    sync();
    for (int f = 0; f < NF; f++) begin
      rd(3'b111, f, "R8 unchanged");
      fs();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule